// File: doc/BRIEF.md
# Address Filter Table Loader

This block fills a 16-entry table of 48-bit station addresses from descriptors that software has placed in system memory. Software programs a descriptor pointer and a descriptor count through a small register interface, then sets a load command bit. The sequencer walks the list one 16-bit word per memory read. Each descriptor holds four words. The first word names the table entry to write, and the next three give the three 16-bit parts of the address. Entries therefore land wherever their descriptors point, not in list order. When the count runs out, one more word is read and kept as the table enable mask. The block then clears the command bit, sets a done status bit and can raise an interrupt.

A configuration bit sets the memory layout. In narrow mode each word sits in a 2-byte slot. In wide mode each word sits in a 4-byte slot and only its low 16 bits are used. A separate input picks big- or little-endian byte order. The memory read port is a valid/ready request channel followed by a one-cycle response pulse, with at most one read in flight. The table contents can be read back through the register interface while a software-reset bit is held.

Top module: `aft_loader`

## Requirements
- R1: Writing a 1 to bit 0 of CMD (register 0) starts a load. While bits [4:0] of COUNT (register 6) are nonzero, the block reads the four words of the current descriptor at PTR + k*S for k = 0..3. S is 2 when CFG (register 1) bit 0 is clear and 4 when it is set. When the count runs out, it reads one more word at PTR. A load of n descriptors therefore issues 4n+1 reads, and read i goes to start_PTR + i*S.
- R2: Response byte lane j (bits 8j+7:8j) carries the byte at request address + j. Narrow little-endian takes {lane1,lane0} and narrow big-endian takes {lane0,lane1}. Wide little-endian takes {lane1,lane0} and wide big-endian takes {lane2,lane3}. Lanes outside the chosen pair never affect a stored value.
- R3: Bits [3:0] of descriptor word 0 select the table entry, and its upper bits are ignored. Words 1, 2 and 3 become parts 0, 1 and 2 of that entry. A later descriptor with the same index overwrites the earlier one.
- R4: After each descriptor, COUNT drops by one and PTR (registers 4 low, 5 high) grows by 8 in narrow mode or 16 in wide mode. COUNT bits above bit 4 keep their value.
- R5: The final word read is stored as the 16-bit enable mask, readable at register 11.
- R6: On completion, CMD bit 0 reads 0 and STATUS (register 2) bit 0 reads 1. Writing 1 to STATUS bit 0 clears it. Writing 0 to CMD bit 0 during a load does not stop the load.
- R7: irq is high exactly while STATUS bit 0 and IRQ_EN (register 3) bit 0 are both set.
- R8: Registers 8, 9 and 10 return parts 0, 1 and 2 of the entry chosen by SEL (register 7) bits [3:0], but only while CMD bit 7 is set. Otherwise they read 0.
- R9: A request holds mem_req_valid and mem_req_addr unchanged until mem_req_ready. No new request appears until the response to the previous one has arrived.
- R10: Writes to PTR and COUNT while CMD bit 0 is set are ignored.
- R11: After reset, every register reads 0, irq is low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Byte order of memory words (1 = big-endian) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_rsp_valid | input | 1 | One-cycle response pulse |
| mem_rsp_data | input | 32 | Response data, lane j = byte at address + j |
| irq | output | 1 | Load-done interrupt |

## Verification
The load path is tested with both slot widths and both byte orders, at random base addresses. The bench fills the unused byte lanes with junk, so picking the wrong lane or the wrong slot spacing shows up as a wrong table entry or a wrong request address. Descriptor lists are tested with:
- random indexes, which tell index placement apart from in-order filling;
- repeated indexes, which check last-writer-wins;
- random upper bits in word 0, which check that only the low four bits select the entry;
- a count whose low five bits are zero but whose upper bits are set, which must produce only the mask read;
- a full list of sixteen descriptors.

Memory back-pressure is random, and so is the response delay. Writes attempted to PTR and COUNT in the middle of a load expose any leak into the walk.

// File: rtl/aft_pkg.sv
package aft_pkg;

  localparam int HALF_W     = 16;
  localparam int DESC_WORDS = 4;
  localparam int PARTS      = DESC_WORDS - 1;
  localparam int RA_W       = 4;

  localparam logic [RA_W-1:0] A_CMD  = 4'd0;
  localparam logic [RA_W-1:0] A_CFG  = 4'd1;
  localparam logic [RA_W-1:0] A_STAT = 4'd2;
  localparam logic [RA_W-1:0] A_IEN  = 4'd3;
  localparam logic [RA_W-1:0] A_PTRL = 4'd4;
  localparam logic [RA_W-1:0] A_PTRH = 4'd5;
  localparam logic [RA_W-1:0] A_CNT  = 4'd6;
  localparam logic [RA_W-1:0] A_SEL  = 4'd7;
  localparam logic [RA_W-1:0] A_RB0  = 4'd8;
  localparam logic [RA_W-1:0] A_RB1  = 4'd9;
  localparam logic [RA_W-1:0] A_RB2  = 4'd10;
  localparam logic [RA_W-1:0] A_MASK = 4'd11;

  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_SWR_BIT = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_DREQ, S_DWAIT, S_COMMIT, S_MREQ, S_MWAIT, S_DONE
  } seq_state_e;

  // Select the 16-bit value from a 32-bit response whose lane j is byte addr+j.
  function automatic logic [HALF_W-1:0] pick_half(input logic [31:0] d,
                                                  input logic wide,
                                                  input logic be);
    logic [HALF_W-1:0] v;
    if (!wide) v = be ? {d[7:0], d[15:8]}   : d[15:0];
    else       v = be ? {d[23:16], d[31:24]} : d[15:0];
    return v;
  endfunction

endpackage

// File: rtl/aft_table.sv
module aft_table
  import aft_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [PARTS-1:0][HALF_W-1:0] wr_parts,
  input  logic                         mask_we,
  input  logic [N_ENT-1:0]             mask_in,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [PARTS-1:0][HALF_W-1:0] rd_parts,
  output logic [N_ENT-1:0]             mask_out
);

  logic [PARTS-1:0][HALF_W-1:0] bank [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [PARTS-1:0][HALF_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ent_q <= '0;
      else if (we && wr_idx == IDX_W'(e))        ent_q <= wr_parts;
    end
    assign bank[e] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_out <= '0;
    else if (mask_we) mask_out <= mask_in;
  end

  assign rd_parts = bank[rd_idx];

endmodule

// File: rtl/aft_seq.sv
module aft_seq
  import aft_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_ENT  = 16,
  parameter int IDX_W  = $clog2(N_ENT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go,
  input  logic                         wide,
  input  logic                         big_endian,
  input  logic [ADDR_W-1:0]            ptr,
  input  logic                         cnt_live,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [ADDR_W-1:0]            mem_req_addr,
  input  logic                         mem_rsp_valid,
  input  logic [31:0]                  mem_rsp_data,
  output logic                         tbl_we,
  output logic [IDX_W-1:0]             tbl_idx,
  output logic [PARTS-1:0][HALF_W-1:0] tbl_parts,
  output logic                         mask_we,
  output logic [N_ENT-1:0]             mask_val,
  output logic                         adv,
  output logic                         done
);

  localparam int WIDX_W = $clog2(DESC_WORDS);

  seq_state_e                   st_q;
  logic [WIDX_W-1:0]            widx_q;
  logic [IDX_W-1:0]             idx_q;
  logic [PARTS-1:0][HALF_W-1:0] part_q;
  logic [HALF_W-1:0]            cur;
  logic                         last_word;

  assign cur       = pick_half(mem_rsp_data, wide, big_endian);
  assign last_word = (widx_q == WIDX_W'(DESC_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      widx_q <= '0;
      idx_q  <= '0;
      part_q <= '0;
    end else begin
      case (st_q)
        S_IDLE:  if (go) st_q <= S_EVAL;
        S_EVAL: begin
          widx_q <= '0;
          st_q   <= cnt_live ? S_DREQ : S_MREQ;
        end
        S_DREQ:  if (mem_req_ready) st_q <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          if (widx_q == '0) idx_q <= cur[IDX_W-1:0];
          for (int k = 1; k < DESC_WORDS; k++) begin
            if (widx_q == WIDX_W'(k)) part_q[k-1] <= cur;
          end
          if (last_word) begin
            st_q <= S_COMMIT;
          end else begin
            widx_q <= widx_q + 1'b1;
            st_q   <= S_DREQ;
          end
        end
        S_COMMIT: st_q <= S_EVAL;
        S_MREQ:  if (mem_req_ready) st_q <= S_MWAIT;
        S_MWAIT: if (mem_rsp_valid) st_q <= S_DONE;
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == S_DREQ) || (st_q == S_MREQ);
  assign mem_req_addr  = ptr + (ADDR_W'(widx_q) << (wide ? 2 : 1));
  assign tbl_we        = (st_q == S_COMMIT);
  assign tbl_idx       = idx_q;
  assign tbl_parts     = part_q;
  assign mask_we       = (st_q == S_MWAIT) && mem_rsp_valid;
  assign mask_val      = N_ENT'(cur);
  assign adv           = (st_q == S_COMMIT);
  assign done          = (st_q == S_DONE);

endmodule

// File: rtl/aft_regs.sv
module aft_regs
  import aft_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LOOP_W = 5,
  parameter int N_ENT  = 16,
  parameter int IDX_W  = $clog2(N_ENT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr_en,
  input  logic [RA_W-1:0]              reg_addr,
  input  logic [HALF_W-1:0]            reg_wdata,
  output logic [HALF_W-1:0]            reg_rdata,
  input  logic [PARTS-1:0][HALF_W-1:0] rb_parts,
  input  logic [N_ENT-1:0]             mask,
  input  logic                         seq_adv,
  input  logic                         seq_done,
  output logic                         go,
  output logic                         wide,
  output logic [ADDR_W-1:0]            ptr,
  output logic [CNT_W-1:0]             count,
  output logic                         cnt_live,
  output logic [IDX_W-1:0]             sel,
  output logic                         done_st,
  output logic                         irq
);

  localparam int HI_W = ADDR_W - HALF_W;

  logic              swr_q, ien_q;
  logic [ADDR_W-1:0] step;
  logic              wr_cmd, wr_stat, wr_ptrl, wr_ptrh, wr_cnt;

  assign step    = ADDR_W'(DESC_WORDS) << (wide ? 2 : 1);
  assign wr_cmd  = reg_wr_en && reg_addr == A_CMD;
  assign wr_stat = reg_wr_en && reg_addr == A_STAT;
  assign wr_ptrl = reg_wr_en && reg_addr == A_PTRL && !go;
  assign wr_ptrh = reg_wr_en && reg_addr == A_PTRH && !go;
  assign wr_cnt  = reg_wr_en && reg_addr == A_CNT  && !go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go      <= 1'b0;
      swr_q   <= 1'b0;
      wide    <= 1'b0;
      done_st <= 1'b0;
      ien_q   <= 1'b0;
      sel     <= '0;
    end else begin
      if (wr_cmd) begin
        if (reg_wdata[CMD_GO_BIT]) go <= 1'b1;
        swr_q <= reg_wdata[CMD_SWR_BIT];
      end
      if (seq_done) go <= 1'b0;
      if (reg_wr_en && reg_addr == A_CFG) wide  <= reg_wdata[0];
      if (reg_wr_en && reg_addr == A_IEN) ien_q <= reg_wdata[0];
      if (reg_wr_en && reg_addr == A_SEL) sel   <= reg_wdata[IDX_W-1:0];
      if (wr_stat && reg_wdata[0]) done_st <= 1'b0;
      if (seq_done)                done_st <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      count <= '0;
    end else if (seq_adv) begin
      ptr   <= ptr + step;
      count <= count - 1'b1;
    end else begin
      if (wr_ptrl) ptr[HALF_W-1:0]      <= reg_wdata;
      if (wr_ptrh) ptr[ADDR_W-1:HALF_W] <= reg_wdata[HI_W-1:0];
      if (wr_cnt)  count                <= reg_wdata[CNT_W-1:0];
    end
  end

  assign cnt_live = |count[LOOP_W-1:0];
  assign irq      = done_st && ien_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CMD:  begin
        reg_rdata[CMD_GO_BIT]  = go;
        reg_rdata[CMD_SWR_BIT] = swr_q;
      end
      A_CFG:  reg_rdata[0] = wide;
      A_STAT: reg_rdata[0] = done_st;
      A_IEN:  reg_rdata[0] = ien_q;
      A_PTRL: reg_rdata = ptr[HALF_W-1:0];
      A_PTRH: reg_rdata = HALF_W'(ptr[ADDR_W-1:HALF_W]);
      A_CNT:  reg_rdata = HALF_W'(count);
      A_SEL:  reg_rdata = HALF_W'(sel);
      A_RB0:  reg_rdata = swr_q ? rb_parts[0] : '0;
      A_RB1:  reg_rdata = swr_q ? rb_parts[1] : '0;
      A_RB2:  reg_rdata = swr_q ? rb_parts[2] : '0;
      A_MASK: reg_rdata = HALF_W'(mask);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/aft_loader.sv
module aft_loader
  import aft_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_ENT  = 16,
  parameter int CNT_W  = 16,
  parameter int LOOP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              irq
);

  localparam int IDX_W = $clog2(N_ENT);

  logic                         go_w, wide_w, live_w, done_w;
  logic [ADDR_W-1:0]            ptr_w;
  logic [CNT_W-1:0]             count_w;
  logic [IDX_W-1:0]             sel_w, widx_w;
  logic                         tbl_we_w, mask_we_w, adv_w, seq_done_w;
  logic [PARTS-1:0][HALF_W-1:0] wparts_w, rparts_w;
  logic [N_ENT-1:0]             mask_in_w, mask_w;

  aft_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W), .N_ENT(N_ENT), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .rb_parts(rparts_w), .mask(mask_w),
    .seq_adv(adv_w), .seq_done(seq_done_w),
    .go(go_w), .wide(wide_w), .ptr(ptr_w), .count(count_w),
    .cnt_live(live_w), .sel(sel_w), .done_st(done_w), .irq(irq)
  );

  aft_seq #(
    .ADDR_W(ADDR_W), .N_ENT(N_ENT), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go(go_w), .wide(wide_w), .big_endian(big_endian),
    .ptr(ptr_w), .cnt_live(live_w),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tbl_we(tbl_we_w), .tbl_idx(widx_w), .tbl_parts(wparts_w),
    .mask_we(mask_we_w), .mask_val(mask_in_w),
    .adv(adv_w), .done(seq_done_w)
  );

  aft_table #(
    .N_ENT(N_ENT), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_we_w), .wr_idx(widx_w), .wr_parts(wparts_w),
    .mask_we(mask_we_w), .mask_in(mask_in_w),
    .rd_idx(sel_w), .rd_parts(rparts_w), .mask_out(mask_w)
  );

endmodule

// File: rtl/aft_loader_chk.sv
module aft_loader_chk
  import aft_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [RA_W-1:0]   reg_addr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              irq,
  input logic              go_q,
  input logic              done_q,
  input logic [CNT_W-1:0]  count_q
);

  logic in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              in_flight <= 1'b0;
    else if (mem_req_valid && mem_req_ready) in_flight <= 1'b1;
    else if (mem_rsp_valid)                  in_flight <= 1'b0;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !mem_req_valid);

  // R6
  done_clears_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !go_q);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) && !$past(reg_wr_en && reg_addr == A_CNT)
      |-> count_q == CNT_W'($past(count_q) - 1'b1));

  // R7
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q);

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      quiet_in_reset_chk: assert (!mem_req_valid && !irq);
    end
  end

endmodule

bind aft_loader aft_loader_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .irq(irq),
  .go_q(go_w), .done_q(done_w), .count_q(count_w)
);

// File: tb/aft_loader_tb.sv
`timescale 1ns/1ps
module aft_loader_tb;
  import aft_pkg::*;

  logic        clk = 1'b0, rst_n = 1'b0, big_endian = 1'b0, reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        irq;

  always #2.5 clk = ~clk;

  aft_loader u_dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .irq(irq)
  );

  int vec_n = 0, bad_n = 0, pv_n = 0, req_n = 0;
  logic [7:0]  mem [1024];
  logic [31:0] req_log [256];
  logic [15:0] exp_tab [16][3];
  logic [15:0] exp_mask;

  // responder state
  bit          s_v, s_r, s_pend;
  logic [31:0] s_a, s_la;
  int          s_dly;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vec_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(logic [31:0] a);
    return {mem[(a + 3) & 1023], mem[(a + 2) & 1023], mem[(a + 1) & 1023], mem[a & 1023]};
  endfunction

  task automatic put16(logic [31:0] a, logic [15:0] v, bit w, bit be);
    if (!w) begin
      mem[a & 1023]       = be ? v[15:8] : v[7:0];
      mem[(a + 1) & 1023] = be ? v[7:0]  : v[15:8];
    end else if (!be) begin
      mem[a & 1023]       = v[7:0];
      mem[(a + 1) & 1023] = v[15:8];
    end else begin
      mem[(a + 2) & 1023] = v[15:8];
      mem[(a + 3) & 1023] = v[7:0];
    end
  endtask

  task automatic reg_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // memory model: random ready, response 1..3 cycles after acceptance
  initial begin : responder
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        s_v = 0; s_r = 0; s_pend = 0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
        continue;
      end
      mem_rsp_valid = 1'b0;
      if (s_v && s_r) begin
        if (s_pend) pv_n++;
        s_pend = 1; s_la = s_a; s_dly = $urandom_range(0, 2);
        if (req_n < 256) req_log[req_n] = s_a;
        req_n++;
      end else if (s_v && !s_r) begin
        if (!mem_req_valid || mem_req_addr !== s_a) pv_n++;
      end
      if (s_pend) begin
        if (s_dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = rd32(s_la); s_pend = 0;
        end else s_dly--;
      end
      if ((s_pend || mem_rsp_valid) && mem_req_valid) pv_n++;
      mem_req_ready = ($urandom_range(0, 3) != 0);
      s_v = mem_req_valid; s_a = mem_req_addr; s_r = mem_req_ready;
    end
  end

  task automatic run_case(int n, bit w, bit be, logic [31:0] base,
                          logic [15:0] cnt_hi, bit ien, bit dup);
    logic [15:0] cnt0, d, hv;
    logic [3:0]  ix;
    int          stride, t;
    logic [31:0] endp;
    cnt0   = {cnt_hi[15:5], 5'(n)};
    stride = w ? 4 : 2;
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    for (int j = 0; j < n; j++) begin
      ix = dup ? 4'(j % 2 + 9) : 4'($urandom);
      put16(base + 32'(4 * j * stride), {12'($urandom), ix}, w, be);
      for (int k = 1; k < 4; k++) begin
        hv = 16'($urandom);
        put16(base + 32'((4 * j + k) * stride), hv, w, be);
        exp_tab[ix][k-1] = hv;
      end
    end
    exp_mask = 16'($urandom);
    put16(base + 32'(4 * n * stride), exp_mask, w, be);
    endp = base + 32'(4 * n * stride);

    @(negedge clk);
    big_endian = be;
    reg_write(A_IEN, {15'd0, ien});
    reg_write(A_CFG, {15'd0, w});
    reg_write(A_PTRL, base[15:0]);
    reg_write(A_PTRH, base[31:16]);
    reg_write(A_CNT, cnt0);
    req_n = 0; pv_n = 0;
    reg_write(A_CMD, 16'h0001);
    if (n >= 2) begin
      // R10: pointer and count writes during a load are dropped
      reg_write(A_PTRL, 16'h0200);
      reg_write(A_CNT, 16'h001f);
      // R6: writing 0 to the command bit does not stop the load
      reg_write(A_CMD, 16'h0000);
      reg_read(A_CMD, d);
      chk("R6", "go held during load", {31'd0, d[0]}, 32'd1);
    end
    t = 0;
    do begin reg_read(A_STAT, d); t++; end while (d[0] == 1'b0 && t < 5000);
    chk("R6", "status done set", {31'd0, d[0]}, 32'd1);
    reg_read(A_CMD, d);
    chk("R6", "go cleared at end", {31'd0, d[0]}, 32'd0);
    chk("R7", "irq when done", {31'd0, irq}, {31'd0, ien});

    // R1: number and order of reads
    chk("R1", "read count", 32'(req_n), 32'(4 * n + 1));
    for (int i = 0; i < req_n && i < 4 * n + 1 && i < 256; i++)
      chk("R1", "read address", req_log[i], base + 32'(i * stride));
    chk("R9", "request protocol violations", 32'(pv_n), 32'd0);

    // R4 / R10: final count and pointer
    reg_read(A_CNT, d);
    chk("R4", "count after load", {16'd0, d}, {16'd0, cnt0 - 16'(n)});
    reg_read(A_PTRL, d);
    chk("R4", "pointer low after load", {16'd0, d}, {16'd0, endp[15:0]});
    reg_read(A_PTRH, d);
    chk("R4", "pointer high after load", {16'd0, d}, {16'd0, endp[31:16]});

    reg_read(A_MASK, d);
    chk("R5", "enable mask", {16'd0, d}, {16'd0, exp_mask});

    // R8: readback hidden while the soft-reset bit is clear
    reg_write(A_SEL, 16'($urandom_range(0, 15)));
    reg_read(A_RB1, d);
    chk("R8", "readback gated", {16'd0, d}, 32'd0);

    reg_write(A_CMD, 16'h0080);
    for (int e = 0; e < 16; e++) begin
      reg_write(A_SEL, 16'(e));
      for (int p = 0; p < 3; p++) begin
        reg_read(4'(8 + p), d);
        chk("R3", "entry part", {16'd0, d}, {16'd0, exp_tab[e][p]});
      end
    end
    reg_write(A_CMD, 16'h0000);

    // R6 / R7: status clear by writing one
    reg_write(A_STAT, 16'h0001);
    reg_read(A_STAT, d);
    chk("R6", "status cleared", {31'd0, d[0]}, 32'd0);
    chk("R7", "irq after clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    bad_n++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    void'($urandom(32'h00c0ffee));
    for (int e = 0; e < 16; e++)
      for (int p = 0; p < 3; p++) exp_tab[e][p] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    for (int a = 0; a < 12; a++) begin
      reg_read(4'(a), d);
      chk("R11", "register after reset", {16'd0, d}, 32'd0);
    end
    chk("R11", "irq after reset", {31'd0, irq}, 32'd0);
    chk("R11", "no request after reset", {31'd0, mem_req_valid}, 32'd0);

    // directed corners
    run_case(3,  1'b0, 1'b0, 32'h0000_0010, 16'h0000, 1'b1, 1'b0); // R2 narrow LE
    run_case(3,  1'b1, 1'b1, 32'h0000_0040, 16'h0020, 1'b1, 1'b0); // R2 wide BE
    run_case(5,  1'b0, 1'b1, 32'h0001_0022, 16'h0000, 1'b0, 1'b1); // R3 duplicates, R7 irq off
    run_case(0,  1'b1, 1'b0, 32'h0000_0100, 16'h0020, 1'b1, 1'b0); // R1 low bits zero
    run_case(16, 1'b1, 1'b0, 32'h0000_0100, 16'h0000, 1'b1, 1'b0); // full list wide
    run_case(16, 1'b0, 1'b1, 32'h0000_0006, 16'h07e0, 1'b1, 1'b0); // full list narrow

    // constrained random
    for (int r = 0; r < 8; r++) begin
      run_case($urandom_range(0, 16), 1'($urandom), 1'($urandom),
               {16'($urandom), 16'($urandom_range(0, 511))},
               16'($urandom) & 16'hffe0, 1'($urandom), 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

endmodule